// File: doc/BRIEF.md
# Data Memory Overlay Address Decoder

This block sits between a processor core's data-memory request port and the memories behind it. It takes a 14-bit word address with read and write strokes and routes each access to one of four places: on-chip RAM, a window of 32 memory-mapped control registers at the very top of the space, or one of two external overlay banks. The upper half of the space (0x2000 to 0x3FFF) is always on chip. A 2-bit overlay selector decides whether the lower half (0x0000 to 0x1FFF) goes to internal RAM or to an external bank.

On-chip hits are signalled by enable outputs in the same cycle, and they never stall. An external hit raises a select strobe and drives the external address bus. The bank number goes on the top address bit and the low 13 address bits pass through unchanged. The ready output is pulled low for the number of wait states held in the wait-count input. The address and bank are captured when the access starts, so the external address holds steady for the whole access, even if the overlay register or the core's address changes partway through.

Top module: `dm_ovl_decoder`

## Requirements
- R1: A request to 0x2000..0x3FDF asserts ram_en_o and never ext_sel_o, whatever the overlay value.
- R2: A request to 0x3FE0..0x3FFF asserts reg_en_o and not ram_en_o, whatever the overlay value.
- R3: A request to 0x0000..0x1FFF with overlay value 0 asserts ram_en_o.
- R4: A request to 0x0000..0x1FFF with overlay value 1 or 2 asserts ext_sel_o. ext_addr_o[12:0] carries address bits 12:0, and ext_addr_o[13] is 0 for overlay 1 and 1 for overlay 2.
- R5: An internal access (RAM or register) completes with ready_o high in its request cycle.
- R6: An external access with wait count N holds ready_o low for exactly N cycles, starting in the request cycle. ext_sel_o stays high for N+1 cycles.
- R7: A lower-half request with overlay value 3 is served by internal RAM and pulses ovl_err_o for that one cycle only.
- R8: The bank and address are captured at the start of an external access. Changing ovl_sel_i or addr_i while ready_o is low leaves ext_addr_o unchanged.
- R9: With no read or write request, and after reset, all enables, ext_sel_o and ovl_err_o are low, ext_addr_o is 0 and ready_o is high.
- R10: While ready_o is low, new requests are ignored: ram_en_o and reg_en_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 14 | Data-memory word address |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| ovl_sel_i | input | 2 | Overlay register value |
| wait_cnt_i | input | 3 | Wait states for external accesses |
| ram_en_o | output | 1 | Internal RAM enable |
| reg_en_o | output | 1 | Control-register window enable |
| ext_sel_o | output | 1 | External data-memory select strobe |
| ext_addr_o | output | 14 | External address, bank bit on top |
| ready_o | output | 1 | Low while the core must stall |
| ovl_err_o | output | 1 | Reserved overlay value used |

## Verification
Two functions can land in the same cycle. One is the final, released cycle of a stalled external access. The other is a request that must be ignored, or a change in the overlay value. The bench starts an external access with a nonzero wait count and, on the cycle after it starts, switches the overlay value and moves the address into the register window. It then judges each cycle: ext_addr_o must keep the captured bank and address, reg_en_o and ram_en_o must stay low, and the ready-low and select-high cycle counts must match the wait count. A separate test issues an internal request on the cycle right after an external access completes and expects it to be served at once.

// File: rtl/dm_ovl_pkg.sv
package dm_ovl_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_REG  = 2'd2,
    TGT_EXT  = 2'd3
  } tgt_e;
endpackage

// File: rtl/dm_region_decode.sv
module dm_region_decode
  import dm_ovl_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int OVL_W   = 2,
  parameter int REG_CNT = 32
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OVL_W-1:0]  ovl_i,
  output tgt_e              tgt_o,
  output logic              bank_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'((1 << ADDR_W) - REG_CNT);

  always_comb begin
    tgt_o  = TGT_NONE;
    bank_o = 1'b0;
    err_o  = 1'b0;
    if (req_i) begin
      if (addr_i[ADDR_W-1]) begin
        // upper half is always on chip
        tgt_o = (addr_i >= REG_BASE) ? TGT_REG : TGT_RAM;
      end else begin
        case (ovl_i)
          OVL_W'(0): tgt_o = TGT_RAM;
          OVL_W'(1): tgt_o = TGT_EXT;
          OVL_W'(2): begin
            tgt_o  = TGT_EXT;
            bank_o = 1'b1;
          end
          default: begin
            tgt_o = TGT_RAM;
            err_o = 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dm_wait_ctrl.sv
module dm_wait_ctrl #(
  parameter int WAIT_W = 3,
  parameter int LOW_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              bank_i,
  input  logic [LOW_W-1:0]  addr_lo_i,
  output logic              busy_o,
  output logic              stall_o,
  output logic              sel_o,
  output logic [LOW_W:0]    ext_addr_o
);
  logic              busy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              bank_q;
  logic [LOW_W-1:0]  addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= 1'b0;
      addr_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i && wait_i != '0) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_i - 1'b1;
      bank_q <= bank_i;
      addr_q <= addr_lo_i;
    end
  end

  always_comb begin
    sel_o      = 1'b0;
    stall_o    = 1'b0;
    ext_addr_o = '0;
    if (busy_q) begin
      sel_o      = 1'b1;
      stall_o    = (cnt_q != '0);
      ext_addr_o = {bank_q, addr_q};
    end else if (start_i) begin
      sel_o      = 1'b1;
      stall_o    = (wait_i != '0);
      ext_addr_o = {bank_i, addr_lo_i};
    end
  end

  assign busy_o = busy_q;

  p_cnt_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  p_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0) |=> !busy_q);
  p_hold_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(ext_addr_o));
endmodule

// File: rtl/dm_ovl_decoder.sv
module dm_ovl_decoder
  import dm_ovl_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int OVL_W   = 2,
  parameter int WAIT_W  = 3,
  parameter int REG_CNT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [OVL_W-1:0]  ovl_sel_i,
  input  logic [WAIT_W-1:0] wait_cnt_i,
  output logic              ram_en_o,
  output logic              reg_en_o,
  output logic              ext_sel_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              ready_o,
  output logic              ovl_err_o
);
  localparam int LOW_W = ADDR_W - 1;

  tgt_e tgt;
  logic bank, err, busy, stall, accept;

  assign accept = (rd_i | wr_i) & ~busy;

  dm_region_decode #(
    .ADDR_W (ADDR_W),
    .OVL_W  (OVL_W),
    .REG_CNT(REG_CNT)
  ) u_dec (
    .req_i (accept),
    .addr_i(addr_i),
    .ovl_i (ovl_sel_i),
    .tgt_o (tgt),
    .bank_o(bank),
    .err_o (err)
  );

  dm_wait_ctrl #(
    .WAIT_W(WAIT_W),
    .LOW_W (LOW_W)
  ) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tgt == TGT_EXT),
    .wait_i    (wait_cnt_i),
    .bank_i    (bank),
    .addr_lo_i (addr_i[LOW_W-1:0]),
    .busy_o    (busy),
    .stall_o   (stall),
    .sel_o     (ext_sel_o),
    .ext_addr_o(ext_addr_o)
  );

  assign ram_en_o  = (tgt == TGT_RAM);
  assign reg_en_o  = (tgt == TGT_REG);
  assign ovl_err_o = err;
  assign ready_o   = ~stall;

  p_upper_int_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && ready_o && addr_i[ADDR_W-1] && !$past(ext_sel_o && !ready_o)) |-> !ext_sel_o);
  p_int_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o || reg_en_o) |-> ready_o);
  p_err_int_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_err_o |-> (ram_en_o && !ext_sel_o));
  p_stall_no_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!ram_en_o && !reg_en_o && ext_sel_o));
endmodule

// File: tb/dm_ovl_decoder_bench.sv
module dm_ovl_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  ovl_sel_i = '0;
  logic [2:0]  wait_cnt_i = '0;
  logic        ram_en_o, reg_en_o, ext_sel_o, ready_o, ovl_err_o;
  logic [13:0] ext_addr_o;

  int tests = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  dm_ovl_decoder u_dm_ovl_decoder (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [13:0] a;
    logic [1:0]  ov;
    logic        rd;
    logic        wr;
    logic        ram;
    logic        rg;
    logic        sel;
    logic [13:0] ea;
    logic        err;
  } vec_t;

  localparam vec_t VECS [0:10] = '{
    '{4'd1, 14'h2000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b0}, // R1
    '{4'd1, 14'h3FDF, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b0}, // R1
    '{4'd2, 14'h3FE0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b0}, // R2
    '{4'd2, 14'h3FFF, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b0}, // R2
    '{4'd3, 14'h0000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b0}, // R3
    '{4'd4, 14'h1FFF, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 14'h1FFF, 1'b0}, // R4
    '{4'd4, 14'h1ABC, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 14'h3ABC, 1'b0}, // R4
    '{4'd7, 14'h0123, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b1}, // R7
    '{4'd1, 14'h2ABC, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b0}, // R1
    '{4'd9, 14'h1555, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0000, 1'b0}, // R9
    '{4'd3, 14'h1FFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b0}  // R3
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk_i);
    #2;
  endtask

  // external access held by the core until ready; optional disturbance in cycle 1
  task automatic run_ext(input logic [13:0] a, input logic [1:0] ov, input logic [2:0] n,
                         input logic disturb);
    int lows = 0;
    int sels = 0;
    logic [13:0] exp_ea;
    exp_ea = {(ov == 2'd2), a[12:0]};
    @(negedge clk_i);
    addr_i = a; ovl_sel_i = ov; wait_cnt_i = n; rd_i = 1'b1; wr_i = 1'b0;
    for (int c = 0; c < 20; c++) begin
      #2;
      if (ext_sel_o) sels++;
      if (!ready_o) lows++;
      chk("R8", "ext_addr during access", 32'(ext_addr_o), 32'(exp_ea));
      chk("R10", "enables during access", {30'd0, ram_en_o, reg_en_o}, 32'd0);
      if (ready_o) break;
      @(negedge clk_i);
      if (disturb) begin
        ovl_sel_i = 2'd1 + {1'b0, ~ov[1]};
        addr_i = 14'h3FE0;
      end
    end
    chk("R6", "ready low cycles", 32'(lows), 32'(n));
    chk("R6", "select high cycles", 32'(sels), 32'(n) + 1);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2;
    chk("R9", "ready in reset", 32'(ready_o), 32'd1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    chk("R9", "idle outputs", {ram_en_o, reg_en_o, ext_sel_o, ovl_err_o, ready_o, ext_addr_o}, {4'b0000, 1'b1, 14'h0});

    // table walk, zero wait states
    wait_cnt_i = 3'd0;
    foreach (VECS[i]) begin
      @(negedge clk_i);
      addr_i = VECS[i].a; ovl_sel_i = VECS[i].ov; rd_i = VECS[i].rd; wr_i = VECS[i].wr;
      #2;
      chk($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d enables", i),
          {ram_en_o, reg_en_o, ext_sel_o, ovl_err_o}, {VECS[i].ram, VECS[i].rg, VECS[i].sel, VECS[i].err});
      chk($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d ext_addr", i), 32'(ext_addr_o), 32'(VECS[i].ea));
      chk("R5", $sformatf("vec %0d ready", i), 32'(ready_o), 32'd1);
    end
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;

    // R7: error flag gone on the following idle cycle
    @(negedge clk_i);
    addr_i = 14'h0040; ovl_sel_i = 2'd3; rd_i = 1'b1;
    #2;
    chk("R7", "err pulse", 32'(ovl_err_o), 32'd1);
    @(negedge clk_i);
    rd_i = 1'b0;
    #2;
    chk("R7", "err cleared", 32'(ovl_err_o), 32'd0);

    // R6, R8, R10: stalled accesses with mid-access disturbance
    run_ext(14'h0F0F, 2'd2, 3'd3, 1'b1);
    run_ext(14'h1234, 2'd1, 3'd7, 1'b1);
    run_ext(14'h0001, 2'd2, 3'd1, 1'b0);

    // R5: internal request right after an external access completes
    @(negedge clk_i);
    addr_i = 14'h0777; ovl_sel_i = 2'd1; wait_cnt_i = 3'd2; wr_i = 1'b1;
    settle();
    settle();
    chk("R6", "last ext cycle ready", 32'(ready_o), 32'd1);
    @(negedge clk_i);
    addr_i = 14'h3FF0; wr_i = 1'b0; rd_i = 1'b1;
    #2;
    chk("R5", "reg hit after ext", {30'd0, reg_en_o, ready_o}, 32'd3);
    chk("R2", "no ram on reg hit", 32'(ram_en_o), 32'd0);
    @(negedge clk_i);
    rd_i = 1'b0;
    #2;
    chk("R9", "idle after traffic", {ram_en_o, reg_en_o, ext_sel_o, ready_o}, 4'b0001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule